// File: doc/BRIEF.md
# Switch-Gated Whole-Pulse Gate

This block sits between a hand-operated on/off switch and a slow periodic pulse train. Both inputs arrive asynchronously and are sampled by a faster system clock. The block forwards the pulse train to its output only while the switch is on. Each pulse that leaves the block has exactly the width it had on the input. A pulse is never clipped at its leading or trailing edge, whenever the switch is operated.

The raw switch level first passes through a two-stage synchronizer. A debouncer then accepts a new level only after it has held steady for a programmable number of system clocks. The pulse train goes through its own two-stage synchronizer. A single stored enable bit gates the synchronized train. That bit may take a new value only on cycles when the synchronized train is low, so it is frozen for the whole of any high phase.

Top module: `sw_pulse_gate`

## Requirements
- R1: While rst_ni is low and right after its release, pulse_o is 0, sw_level_o is 0 and the stored enable is 0.
- R2: sw_level_o takes the new raw switch level exactly SYNC_STAGES + STABLE_CYC clock edges after a change of sw_raw_i that then stays put (18 edges with the defaults 2 and 16).
- R3: A raw switch that toggles with every level lasting fewer than STABLE_CYC clocks never changes sw_level_o.
- R4: While the gate is open, pulse_o follows pulse_i with a latency of SYNC_STAGES clock edges (2 with the defaults).
- R5: The enable is loaded from sw_level_o only on cycles where the synchronized pulse is low. If the switch turns on while pulse_i is held high, pulse_o stays 0 until pulse_i has gone low and risen again.
- R6: If the switch turns off while an output pulse is high, pulse_o stays high until pulse_i falls, then goes low 2 edges later.
- R7: Every pulse on pulse_o is high for exactly as many clocks as the matching pulse_i, even when the switch changes during a train.
- R8: With sw_level_o settled at 0, no pulse appears on pulse_o.
- R9: With sw_level_o settled at 1, every pulse of pulse_i appears on pulse_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, faster than the pulse train |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_raw_i | input | 1 | Raw, bouncing switch level (1 = on) |
| pulse_i | input | 1 | Asynchronous periodic pulse train |
| pulse_o | output | 1 | Gated pulse train, whole pulses only |
| sw_level_o | output | 1 | Debounced, synchronized switch level |

## Verification
The assertions assume that pulse_i holds each level for several system clocks, so that its synchronized copy has clean, multi-cycle high and low phases. They also assume that the switch bounces on a scale the debounce window can separate. The bench drives both inputs on the falling clock edge. It uses pulses of 8 clocks high and 12 low, and bounce intervals of 5 clocks against a 16-clock window. Switch changes are placed both inside high phases and inside low phases of the train, so the frozen-enable rule is hit from both sides.

// File: rtl/sw_gate_pkg.sv
package sw_gate_pkg;
  localparam int unsigned DEF_STABLE_CYC  = 16;
  localparam int unsigned DEF_SYNC_STAGES = 2;

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit);
  endfunction
endpackage

// File: rtl/sg_sync.sv
module sg_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[s] <= RST_VAL;
          else         chain_q[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[s] <= RST_VAL;
          else         chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sg_debounce.sv
module sg_debounce
  import sw_gate_pkg::*;
#(
  parameter int unsigned STABLE_CYC = DEF_STABLE_CYC
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sw_sync_i,
  output logic level_o
);
  localparam int unsigned CW = cnt_width(STABLE_CYC);
  localparam logic [CW-1:0] LAST = CW'(STABLE_CYC - 1);

  logic [CW-1:0] dwell_q;
  logic          level_q;
  logic          differs;

  assign differs = sw_sync_i ^ level_q;

  // count consecutive samples that disagree with the accepted level
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dwell_q <= '0;
      level_q <= 1'b0;
    end else if (!differs) begin
      dwell_q <= '0;
    end else if (dwell_q == LAST) begin
      dwell_q <= '0;
      level_q <= sw_sync_i;
    end else begin
      dwell_q <= dwell_q + 1'b1;
    end
  end

  assign level_o = level_q;
endmodule

// File: rtl/sg_gate.sv
module sg_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pulse_sync_i,
  input  logic en_req_i,
  output logic en_o,
  output logic pulse_o
);
  logic en_q;

  // enable may only move while the train is low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            en_q <= 1'b0;
    else if (!pulse_sync_i) en_q <= en_req_i;
  end

  assign en_o    = en_q;
  assign pulse_o = pulse_sync_i & en_q;
endmodule

// File: rtl/sw_pulse_gate.sv
module sw_pulse_gate
  import sw_gate_pkg::*;
#(
  parameter int unsigned STABLE_CYC  = DEF_STABLE_CYC,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sw_raw_i,
  input  logic pulse_i,
  output logic pulse_o,
  output logic sw_level_o
);
  logic sw_sync;
  logic pulse_sync;
  logic gate_en;

  sg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sw_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sw_raw_i),
    .q_o   (sw_sync)
  );

  sg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_pulse_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pulse_i),
    .q_o   (pulse_sync)
  );

  sg_debounce #(.STABLE_CYC(STABLE_CYC)) i_debounce (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sw_sync_i(sw_sync),
    .level_o  (sw_level_o)
  );

  sg_gate i_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pulse_sync_i(pulse_sync),
    .en_req_i    (sw_level_o),
    .en_o        (gate_en),
    .pulse_o     (pulse_o)
  );
endmodule

// File: rtl/sw_pulse_gate_chk.sv
module sw_pulse_gate_chk #(
  parameter int unsigned STABLE_CYC = 16
) (
  input logic clk_i,
  input logic rst_ni,
  input logic sw_sync,
  input logic sw_level,
  input logic pulse_sync,
  input logic gate_en,
  input logic pulse_o
);
  localparam int unsigned RW = $clog2(STABLE_CYC + 1) + 1;
  localparam logic [RW-1:0] SAT = RW'(STABLE_CYC);

  logic [RW-1:0] run_q;
  logic          lvl_q;

  // independent run length of disagreeing switch samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      lvl_q <= sw_level;
      if (sw_level != lvl_q)       run_q <= (sw_sync != sw_level) ? RW'(1) : '0;
      else if (sw_sync != sw_level) run_q <= (run_q == SAT) ? SAT : run_q + 1'b1;
      else                          run_q <= '0;
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> (!pulse_o && !sw_level && !gate_en));

  a_r2_dwell_met: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_level != lvl_q) |-> (run_q >= SAT));

  a_r5_en_frozen_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_sync && $past(pulse_sync)) |-> $stable(gate_en));

  a_r7_rise_with_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_o) |-> $rose(pulse_sync));

  a_r7_fall_with_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pulse_o) |-> $fell(pulse_sync));
endmodule

bind sw_pulse_gate sw_pulse_gate_chk #(.STABLE_CYC(STABLE_CYC)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sw_sync   (sw_sync),
  .sw_level  (sw_level_o),
  .pulse_sync(pulse_sync),
  .gate_en   (gate_en),
  .pulse_o   (pulse_o)
);

// File: tb/test_sw_pulse_gate.sv
`timescale 1ns/1ps
module test_sw_pulse_gate;
  localparam int HI = 8;
  localparam int LO = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_raw = 1'b0;
  logic pulse_in = 1'b0;
  logic pulse_out;
  logic sw_level;

  int checks = 0;
  int errors = 0;
  int out_cnt = 0;
  int bad_len = 0;
  int run_len = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sw_pulse_gate i_sw_pulse_gate (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .sw_raw_i  (sw_raw),
    .pulse_i   (pulse_in),
    .pulse_o   (pulse_out),
    .sw_level_o(sw_level)
  );

  // output pulse length monitor (R7)
  always @(negedge clk) begin
    if (!mon_on) begin
      run_len = 0;
    end else if (pulse_out) begin
      run_len++;
    end else if (run_len > 0) begin
      out_cnt++;
      if (run_len != HI) begin
        bad_len++;
        $display("FAIL R7 pulse width actual=%0d expected=%0d", run_len, HI);
      end
      run_len = 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic train(input int periods);
    for (int p = 0; p < periods; p++) begin
      pulse_in = 1'b1; cyc(HI);
      pulse_in = 1'b0; cyc(LO);
    end
  endtask

  task automatic t_reset();
    fork
      train(2);
    join_none
    cyc(10);
    chk(pulse_out == 1'b0, "R1 pulse_o in reset", pulse_out, 0);
    chk(sw_level == 1'b0, "R1 level in reset", sw_level, 0);
    wait fork;
    rst_n = 1'b1;
    cyc(1);
    chk(pulse_out == 1'b0 && sw_level == 1'b0, "R1 after release", pulse_out, 0);
  endtask

  task automatic t_debounce_latency();
    sw_raw = 1'b1;
    cyc(17);
    chk(sw_level == 1'b0, "R2 level before 18 edges", sw_level, 0);
    cyc(1);
    chk(sw_level == 1'b1, "R2 level at 18 edges", sw_level, 1);
  endtask

  task automatic t_bounce();
    int flips = 0;
    for (int i = 0; i < 10; i++) begin
      sw_raw = ~sw_raw;
      for (int k = 0; k < 5; k++) begin
        @(negedge clk);
        if (sw_level != 1'b1) flips++;
      end
    end
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (sw_level != 1'b1) flips++;
    end
    chk(flips == 0, "R3 short bounce kept level", flips, 0);
    for (int i = 0; i < 9; i++) begin
      sw_raw = ~sw_raw;
      cyc(5);
    end
    chk(sw_raw == 1'b0, "R3 bounce ends low", sw_raw, 0);
    chk(sw_level == 1'b1, "R3 level held during bounce", sw_level, 1);
    cyc(13);
    chk(sw_level == 1'b0, "R2 settle after bounce", sw_level, 0);
  endtask

  task automatic t_off_quiet();
    int c0 = out_cnt;
    mon_on = 1'b1;
    train(10);
    cyc(4);
    chk(out_cnt == c0, "R8 no output when off", out_cnt - c0, 0);
  endtask

  task automatic t_on_mid_train();
    int c0 = out_cnt;
    int b0 = bad_len;
    fork
      train(30);
      begin cyc(37); sw_raw = 1'b1; end
    join
    cyc(4);
    chk(bad_len == b0, "R7 whole pulses at switch-on", bad_len - b0, 0);
    chk(out_cnt - c0 >= 25 && out_cnt - c0 <= 28, "R9 pulses after switch-on",
        out_cnt - c0, 27);
  endtask

  task automatic t_on_count();
    int c0 = out_cnt;
    train(10);
    cyc(4);
    chk(out_cnt - c0 == 10, "R9 every pulse passed", out_cnt - c0, 10);
  endtask

  task automatic t_latency();
    pulse_in = 1'b1;
    cyc(1);
    chk(pulse_out == 1'b0, "R4 one edge after rise", pulse_out, 0);
    cyc(1);
    chk(pulse_out == 1'b1, "R4 two edges after rise", pulse_out, 1);
    cyc(HI - 2);
    pulse_in = 1'b0;
    cyc(LO);
  endtask

  task automatic t_off_mid_train();
    int b0 = bad_len;
    fork
      train(20);
      begin cyc(63); sw_raw = 1'b0; end
    join
    cyc(4);
    chk(bad_len == b0, "R7 whole pulses at switch-off", bad_len - b0, 0);
    chk(sw_level == 1'b0, "R8 level off after train", sw_level, 0);
  endtask

  task automatic t_on_while_high();
    mon_on = 1'b0;
    pulse_in = 1'b1;
    cyc(5);
    sw_raw = 1'b1;
    cyc(30);
    chk(sw_level == 1'b1, "R5 level on", sw_level, 1);
    chk(pulse_out == 1'b0, "R5 gate stays shut while high", pulse_out, 0);
    pulse_in = 1'b0;
    cyc(4);
    chk(pulse_out == 1'b0, "R5 low phase output", pulse_out, 0);
    pulse_in = 1'b1;
    cyc(1);
    chk(pulse_out == 1'b0, "R5 next rise pending", pulse_out, 0);
    cyc(1);
    chk(pulse_out == 1'b1, "R5 next pulse passed", pulse_out, 1);
  endtask

  task automatic t_off_while_high();
    sw_raw = 1'b0;
    cyc(30);
    chk(sw_level == 1'b0, "R6 level off", sw_level, 0);
    chk(pulse_out == 1'b1, "R6 pulse held to its end", pulse_out, 1);
    pulse_in = 1'b0;
    cyc(1);
    chk(pulse_out == 1'b1, "R6 one edge after fall", pulse_out, 1);
    cyc(1);
    chk(pulse_out == 1'b0, "R6 two edges after fall", pulse_out, 0);
    cyc(4);
    pulse_in = 1'b1;
    cyc(4);
    chk(pulse_out == 1'b0, "R6 later pulse blocked", pulse_out, 0);
    pulse_in = 1'b0;
    cyc(4);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_debounce_latency();
    t_bounce();
    t_off_quiet();
    t_on_mid_train();
    t_on_count();
    t_latency();
    t_off_mid_train();
    t_on_while_high();
    t_off_while_high();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule